// File: doc/BRIEF.md
# Processor-Side Interrupt Acknowledge Port

This block is the per-processor end of an interrupt controller. A distributor drives it with a level pending bit and a priority for every source forwarded to this processor. The block picks the most urgent eligible source and raises a request line to the processor. It then runs the acknowledge and completion handshake over a small register port. One instance serves one processor. A register access that software issues at the shared processor-side address is routed to the instance of the processor that made it.

Reading the acknowledge register returns the chosen source ID and marks that source active. The block also pulses the ID back to the distributor so the distributor can drop its pending bit. An active source is not offered again until software writes its ID to the completion register. IDs 0 to 15 are software-generated. For these, the acknowledge word also carries the sending processor, and software echoes the whole word back on completion. When nothing is deliverable, the read returns the spurious ID 1023 and changes nothing.

The register port is a valid/ready command stream plus a valid/ready read-response stream. A command is accepted when `cmd_valid` and `cmd_ready` are both high. Only reads produce a response. `cmd_ready` is low while a response is waiting and `rsp_ready` is low. A waiting response holds its data stable until it is taken.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset, `irq_o` is 0, `rsp_valid` is 0, the enable bit and the priority mask both read 0, and no source is active.
- R2: Register selects on `cmd_addr`. 0 is control: bit 0 is the enable, read back with zero upper bits. 1 is the priority mask: the low 8 bits are read and written. 2 is acknowledge (read). 3 is completion (write). A read of select 3 returns 0, and a write to select 2 changes no state.
- R3: `irq_o` is high exactly when the enable is set and at least one source is pending, not active, and has a priority below the mask.
- R4: An acknowledge read returns, in bits [9:0], the eligible source with the numerically lowest priority. Ties go to the lowest ID.
- R5: When the acknowledged ID is below 16, bits [12:10] carry that ID's 3-bit sender field from `sgi_src_i` (field n at bits [3n+2:3n]). For other IDs those bits are 0, and all bits above 12 are 0.
- R6: A granted acknowledge marks the source active and pulses `ack_vld_o` with `ack_id_o` in the cycle its response becomes valid. An active source is not presented again, even while still pending, until completed.
- R7: With no eligible source, or with the enable clear, an acknowledge read returns 1023, produces no pulse and changes no active state.
- R8: A write to completion with ID bits [9:0] clears that source's active state. IDs that are not implemented, or not active, are ignored.
- R9: A read response stays valid with unchanged data while `rsp_ready` is low. In that time `cmd_ready` is low.
- R10: The mask comparison is strict: a source whose priority equals the mask is not signalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_IRQ | Level pending bit per source, from the distributor |
| prio_i | input | NUM_IRQ*PRIO_W | Priority per source, source n in bits [n*PRIO_W +: PRIO_W] |
| sgi_src_i | input | 48 | Sender processor per software-generated ID, 3 bits each |
| cmd_valid | input | 1 | Register command valid |
| cmd_ready | output | 1 | Register command accepted this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 2 | Register select |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_rdata | output | 32 | Read response data |
| irq_o | output | 1 | Interrupt request to the processor |
| ack_vld_o | output | 1 | One-cycle pulse per granted acknowledge |
| ack_id_o | output | 10 | ID that was acknowledged |

## Verification
The hardest situation to reach is a source that stays pending after it has been acknowledged while other sources compete with it. This is the only case that shows whether active state, and not the distributor clearing pending, keeps the source off the request line. The random phase keeps many sources pending and draws their priorities from a few coarse levels, so ties are common. When it acknowledges, it clears the distributor pending bit only half of the time. Completions use random IDs, including ones that are not active or not implemented. Directed cases add the equal-to-mask boundary, acknowledge with the enable clear, software-generated IDs with their sender field, and a response held under back-pressure.

// File: rtl/irqcpu_pkg.sv
package irqcpu_pkg;
  localparam int ID_W      = 10;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 2;
  localparam int SRC_W     = 3;
  localparam int SGI_COUNT = 16;
  localparam int MAX_ID    = 510;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CTRL  = 2'd0,
    SEL_PMASK = 2'd1,
    SEL_ACK   = 2'd2,
    SEL_DONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqcpu_prio_select.sv
module irqcpu_prio_select
  import irqcpu_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IRQ-1:0]        elig_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      best_vld_o,
  output logic [ID_W-1:0]           best_id_o,
  output logic [PRIO_W-1:0]         best_prio_o
);
  localparam int LVLS  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
  localparam int LEAVES = 1 << LVLS;

  logic              nd_vld  [1:2*LEAVES-1];
  logic [PRIO_W-1:0] nd_prio [1:2*LEAVES-1];
  logic [ID_W-1:0]   nd_id   [1:2*LEAVES-1];

  for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
    if (g < NUM_IRQ) begin : g_real
      assign nd_vld[LEAVES+g]  = elig_i[g];
      assign nd_prio[LEAVES+g] = prio_i[g*PRIO_W +: PRIO_W];
      assign nd_id[LEAVES+g]   = ID_W'(g);
    end else begin : g_pad
      assign nd_vld[LEAVES+g]  = 1'b0;
      assign nd_prio[LEAVES+g] = '1;
      assign nd_id[LEAVES+g]   = ID_W'(g);
    end
  end

  // Lower-index child wins ties, so equal priorities resolve to the lower ID.
  for (genvar n = 1; n < LEAVES; n++) begin : g_node
    logic take_left;
    assign take_left = nd_vld[2*n] &&
                       (!nd_vld[2*n+1] || (nd_prio[2*n] <= nd_prio[2*n+1]));
    assign nd_vld[n]  = nd_vld[2*n] | nd_vld[2*n+1];
    assign nd_prio[n] = take_left ? nd_prio[2*n] : nd_prio[2*n+1];
    assign nd_id[n]   = take_left ? nd_id[2*n]   : nd_id[2*n+1];
  end

  assign best_vld_o  = nd_vld[1];
  assign best_id_o   = nd_id[1];
  assign best_prio_o = nd_prio[1];

  // R4: the winner is always one of the eligible sources.
  assert_winner_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    best_vld_o |-> (best_id_o < NUM_IRQ) && elig_i[best_id_o[LVLS-1:0]]);

  // R3: a winner exists whenever any source is eligible.
  assert_winner_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|elig_i) |-> best_vld_o);
endmodule

// File: rtl/irqcpu_active_track.sv
module irqcpu_active_track
  import irqcpu_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_vld_i,
  input  logic [ID_W-1:0]    set_id_i,
  input  logic               clr_vld_i,
  input  logic [ID_W-1:0]    clr_id_i,
  output logic [NUM_IRQ-1:0] active_o
);
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic [NUM_IRQ-1:0] active_q;
  logic               clr_hit;

  assign clr_hit = clr_vld_i && (clr_id_i < NUM_IRQ);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= '0;
    end else begin
      if (clr_hit)   active_q[clr_id_i[IDX_W-1:0]] <= 1'b0;
      if (set_vld_i) active_q[set_id_i[IDX_W-1:0]] <= 1'b1;
    end
  end

  assign active_o = active_q;

  // R6: a source is never granted while it is already active.
  assert_no_double_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld_i |-> (set_id_i < NUM_IRQ) && !active_q[set_id_i[IDX_W-1:0]]);

  // R6: a grant leaves the source active.
  assert_grant_marks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld_i |=> active_q[$past(set_id_i[IDX_W-1:0])]);

  // R8: a completion of an implemented ID leaves it inactive.
  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !set_vld_i) |=> !active_q[$past(clr_id_i[IDX_W-1:0])]);

  // R8: an out-of-range completion with no grant leaves all state alone.
  assert_done_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld_i && !clr_hit && !set_vld_i) |=> $stable(active_q));
endmodule

// File: rtl/irqcpu_regs.sv
module irqcpu_regs
  import irqcpu_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_write,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [DATA_W-1:0]          cmd_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  input  logic                       best_vld_i,
  input  logic [ID_W-1:0]            best_id_i,
  input  logic [SGI_COUNT*SRC_W-1:0] sgi_src_i,
  output logic                       enable_o,
  output logic [PRIO_W-1:0]          pmask_o,
  output logic                       grant_o,
  output logic                       done_vld_o,
  output logic [ID_W-1:0]            done_id_o,
  output logic                       ack_vld_o,
  output logic [ID_W-1:0]            ack_id_o
);
  logic              rsp_vld_q;
  logic [DATA_W-1:0] rsp_data_q;
  logic              enable_q;
  logic [PRIO_W-1:0] pmask_q;
  logic              ack_vld_q;
  logic [ID_W-1:0]   ack_id_q;

  logic              fire, rd_fire, wr_fire;
  reg_sel_e          sel;
  logic [SRC_W-1:0]  sender;
  logic [DATA_W-1:0] ack_word;
  logic [DATA_W-1:0] rd_word;
  logic              unused_wdata;

  assign cmd_ready = !rsp_vld_q || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign rd_fire   = fire && !cmd_write;
  assign wr_fire   = fire && cmd_write;
  assign sel       = reg_sel_e'(cmd_addr);

  assign grant_o    = rd_fire && (sel == SEL_ACK) && enable_q && best_vld_i;
  assign done_vld_o = wr_fire && (sel == SEL_DONE);
  assign done_id_o  = cmd_wdata[ID_W-1:0];
  assign unused_wdata = ^cmd_wdata[DATA_W-1:ID_W];

  assign sender = (best_id_i < SGI_COUNT) ?
                  sgi_src_i[best_id_i[3:0]*SRC_W +: SRC_W] : '0;

  always_comb begin
    ack_word = DATA_W'(SPURIOUS_ID);
    if (enable_q && best_vld_i)
      ack_word = DATA_W'({sender, best_id_i});
  end

  always_comb begin
    unique case (sel)
      SEL_CTRL:  rd_word = DATA_W'(enable_q);
      SEL_PMASK: rd_word = DATA_W'(pmask_q);
      SEL_ACK:   rd_word = ack_word;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld_q  <= 1'b0;
      rsp_data_q <= '0;
      enable_q   <= 1'b0;
      pmask_q    <= '0;
      ack_vld_q  <= 1'b0;
      ack_id_q   <= '0;
    end else begin
      if (rsp_vld_q && rsp_ready) rsp_vld_q <= 1'b0;
      if (rd_fire) begin
        rsp_vld_q  <= 1'b1;
        rsp_data_q <= rd_word;
      end
      if (wr_fire && sel == SEL_CTRL)  enable_q <= cmd_wdata[0];
      if (wr_fire && sel == SEL_PMASK) pmask_q  <= cmd_wdata[PRIO_W-1:0];
      ack_vld_q <= grant_o;
      if (grant_o) ack_id_q <= best_id_i;
    end
  end

  assign rsp_valid = rsp_vld_q;
  assign rsp_rdata = rsp_data_q;
  assign enable_o  = enable_q;
  assign pmask_o   = pmask_q;
  assign ack_vld_o = ack_vld_q;
  assign ack_id_o  = ack_id_q;

  // R9: a waiting response keeps its data until it is taken.
  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld_q && !rsp_ready) |=> rsp_vld_q && $stable(rsp_data_q));

  // R6: the distributor pulse comes with the acknowledge response.
  assert_pulse_with_rsp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_q |-> rsp_vld_q && (rsp_data_q[ID_W-1:0] == ack_id_q));

  // R4: a reported ID never exceeds the largest valid ID.
  assert_id_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ack_vld_q |-> (ack_id_q <= MAX_ID));
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
  import irqcpu_pkg::*;
#(
  parameter int NUM_IRQ = 64,
  parameter int PRIO_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_IRQ-1:0]         pend_i,
  input  logic [NUM_IRQ*PRIO_W-1:0]  prio_i,
  input  logic [SGI_COUNT*SRC_W-1:0] sgi_src_i,
  input  logic                       cmd_valid,
  output logic                       cmd_ready,
  input  logic                       cmd_write,
  input  logic [ADDR_W-1:0]          cmd_addr,
  input  logic [DATA_W-1:0]          cmd_wdata,
  output logic                       rsp_valid,
  input  logic                       rsp_ready,
  output logic [DATA_W-1:0]          rsp_rdata,
  output logic                       irq_o,
  output logic                       ack_vld_o,
  output logic [ID_W-1:0]            ack_id_o
);
  logic [NUM_IRQ-1:0] active;
  logic [NUM_IRQ-1:0] elig;
  logic               best_vld;
  logic [ID_W-1:0]    best_id;
  logic [PRIO_W-1:0]  best_prio;
  logic               enable;
  logic [PRIO_W-1:0]  pmask;
  logic               grant;
  logic               done_vld;
  logic [ID_W-1:0]    done_id;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_elig
    assign elig[i] = pend_i[i] && !active[i] &&
                     (prio_i[i*PRIO_W +: PRIO_W] < pmask);
  end

  irqcpu_prio_select #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .elig_i(elig), .prio_i(prio_i),
    .best_vld_o(best_vld), .best_id_o(best_id), .best_prio_o(best_prio)
  );

  irqcpu_active_track #(.NUM_IRQ(NUM_IRQ)) u_act (
    .clk(clk), .rst_n(rst_n),
    .set_vld_i(grant), .set_id_i(best_id),
    .clr_vld_i(done_vld), .clr_id_i(done_id),
    .active_o(active)
  );

  irqcpu_regs #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .best_vld_i(best_vld), .best_id_i(best_id), .sgi_src_i(sgi_src_i),
    .enable_o(enable), .pmask_o(pmask),
    .grant_o(grant), .done_vld_o(done_vld), .done_id_o(done_id),
    .ack_vld_o(ack_vld_o), .ack_id_o(ack_id_o)
  );

  assign irq_o = enable && best_vld;

  // R10: any presented winner sits strictly below the mask.
  assert_mask_strict_R10: assert property (@(posedge clk) disable iff (!rst_n)
    best_vld |-> (best_prio < pmask));

  // R7: an acknowledge read that grants nothing touches no active state.
  assert_spurious_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && !cmd_write && cmd_addr == 2'd2 && !grant && !done_vld)
      |=> $stable(active) && !ack_vld_o);
endmodule

// File: tb/irq_cpu_port_tb_top.sv
module irq_cpu_port_tb_top;
  localparam int N  = 64;
  localparam int PW = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    pend = '0;
  logic [N*PW-1:0] prio = '0;
  logic [47:0]     sgi_src = '0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic            cmd_write = 1'b0;
  logic [1:0]      cmd_addr = '0;
  logic [31:0]     cmd_wdata = '0;
  logic            rsp_valid;
  logic            rsp_ready = 1'b1;
  logic [31:0]     rsp_rdata;
  logic            irq_o;
  logic            ack_vld_o;
  logic [9:0]      ack_id_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_active = '0;
  logic         m_en = 0;
  logic [7:0]   m_pmr = 0;

  logic [31:0] rd_d;
  logic        rd_pulse;
  logic [9:0]  rd_pid;

  always #2.5 clk = ~clk;

  irq_cpu_port #(.NUM_IRQ(N), .PRIO_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .prio_i(prio), .sgi_src_i(sgi_src),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .irq_o(irq_o), .ack_vld_o(ack_vld_o), .ack_id_o(ack_id_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ack();
    int best = -1;
    for (int i = 0; i < N; i++) begin
      if (pend[i] && !m_active[i] && prio[i*PW +: PW] < m_pmr)
        if (best < 0 || prio[i*PW +: PW] < prio[best*PW +: PW]) best = i;
    end
    if (!m_en || best < 0) return 32'd1023;
    if (best < 16) return {19'd0, sgi_src[best*3 +: 3], 10'(best)};
    return 32'(best);
  endfunction

  function automatic logic exp_irq();
    return exp_ack() != 32'd1023;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 0; cmd_write = 0;
    if (a == 2'd0) m_en = d[0];
    if (a == 2'd1) m_pmr = d[7:0];
    if (a == 2'd3 && d[9:0] < N) m_active[d[5:0]] = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
    rd_d = rsp_rdata; rd_pulse = ack_vld_o; rd_pid = ack_id_o;
  endtask

  task automatic ack_check(input string req);
    logic [31:0] e;
    e = exp_ack();
    rd(2'd2);
    chk(req, rd_d, e);
    chk("R6 pulse", {31'd0, rd_pulse}, {31'd0, e != 32'd1023});
    if (e != 32'd1023) begin
      chk("R6 pulse id", {22'd0, rd_pid}, {22'd0, e[9:0]});
      m_active[e[5:0]] = 1'b1;
    end
  endtask

  task automatic set_src(input int id, input logic [7:0] p);
    prio[id*PW +: PW] = p;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) sgi_src[i*3 +: 3] = 3'($urandom % 8);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 rsp_valid", {31'd0, rsp_valid}, 0);
    rd(2'd0); chk("R1 ctrl", rd_d, 0);
    rd(2'd1); chk("R1 pmask", rd_d, 0);

    // R2 register map
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0); chk("R2 ctrl", rd_d, 32'd1);
    wr(2'd1, 32'h0000_01AB); rd(2'd1); chk("R2 pmask", rd_d, 32'hAB);
    rd(2'd3); chk("R2 done read", rd_d, 0);
    wr(2'd1, 32'hF0);

    // R7 nothing pending
    ack_check("R7 spurious idle");
    chk("R3 idle irq", {31'd0, irq_o}, 0);

    // R6 active source not re-presented while still pending
    pend[40] = 1; set_src(40, 8'h20);
    #1 chk("R3 single irq", {31'd0, irq_o}, 1);
    ack_check("R6 first ack");
    chk("R6 irq after ack", {31'd0, irq_o}, 0);
    ack_check("R6 no repeat");
    wr(2'd2, 32'd40);  // R2 write to acknowledge ignored
    chk("R2 ack write ignored", {31'd0, irq_o}, 0);
    wr(2'd3, 32'd41);  // R8 not active: ignored
    chk("R8 other id ignored", {31'd0, irq_o}, 0);
    wr(2'd3, 32'd40);
    chk("R8 done re-arms", {31'd0, irq_o}, 1);

    // R10 strict mask
    wr(2'd1, 32'h20);
    chk("R10 equal masked", {31'd0, irq_o}, 0);
    wr(2'd1, 32'h21);
    chk("R10 below shown", {31'd0, irq_o}, 1);
    wr(2'd1, 32'hF0);

    // R4 ties -> lowest ID, lower prio wins
    pend[35] = 1; set_src(35, 8'h20);
    pend[50] = 1; set_src(50, 8'h10);
    ack_check("R4 lowest prio");
    ack_check("R4 tie lowest id");
    ack_check("R4 remaining");
    wr(2'd3, 32'd50); wr(2'd3, 32'd35); wr(2'd3, 32'd40);
    pend = '0;

    // R5 software IDs carry sender, completed by echoing full word
    pend[3] = 1; set_src(3, 8'h30);
    pend[12] = 1; set_src(12, 8'h30);
    ack_check("R5 sgi word");
    wr(2'd3, rd_d);
    ack_check("R5 sgi again");
    wr(2'd3, rd_d);
    pend = '0; m_active = '0; wr(2'd3, 32'd12);

    // R7 disabled
    pend[20] = 1; set_src(20, 8'h00);
    wr(2'd0, 0);
    chk("R3 disabled irq", {31'd0, irq_o}, 0);
    ack_check("R7 disabled spurious");
    wr(2'd0, 1);
    chk("R3 enabled irq", {31'd0, irq_o}, 1);

    // R9 back-pressure
    @(negedge clk);
    rsp_ready = 0; cmd_valid = 1; cmd_write = 0; cmd_addr = 2'd1;
    @(negedge clk);
    cmd_addr = 2'd0;
    chk("R9 rsp valid", {31'd0, rsp_valid}, 1);
    chk("R9 cmd_ready low", {31'd0, cmd_ready}, 0);
    chk("R9 data", rsp_rdata, 32'hF0);
    @(negedge clk);
    chk("R9 data held", rsp_rdata, 32'hF0);
    rsp_ready = 1;
    @(negedge clk);
    cmd_valid = 0;
    chk("R9 next rsp", rsp_rdata, 32'd1);

    // Random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      op = $urandom % 10;
      if (op < 3) begin
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
          pend[i] = ($urandom % 6) == 0;
          prio[i*PW +: PW] = 8'(($urandom % 8) << 4);
        end
        #1 chk("R3 random irq", {31'd0, irq_o}, {31'd0, exp_irq()});
      end else if (op < 6) begin
        ack_check("R4 random ack");
        if (rd_d != 32'd1023 && ($urandom % 2) == 0) pend[rd_d[5:0]] = 0;
        chk("R3 post-ack irq", {31'd0, irq_o}, {31'd0, exp_irq()});
      end else if (op < 8) begin
        wr(2'd3, 32'($urandom % 80));
        chk("R8 random done", {31'd0, irq_o}, {31'd0, exp_irq()});
      end else if (op == 8) begin
        logic [7:0] pv;
        case ($urandom % 4)
          0: pv = 8'h00; 1: pv = 8'h40; 2: pv = 8'h80; default: pv = 8'hF0;
        endcase
        wr(2'd1, 32'(pv));
        chk("R10 random mask", {31'd0, irq_o}, {31'd0, exp_irq()});
      end else begin
        wr(2'd0, 32'(($urandom % 4) != 0));
        chk("R3 random enable", {31'd0, irq_o}, {31'd0, exp_irq()});
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule